// File: doc/BRIEF.md
# Eight-bit timer with compare flags and PWM

The block is an up-counting timer fed through a selectable clock divider. Two compare channels watch the count, and a wrap from the top value back to zero counts as a third event source. Each of the three sources has a sticky status flag and an enable bit. A set flag raises that source's interrupt request line while its enable is set. The flag drops when the interrupt controller acknowledges it, or when software writes a 1 to it.

A small register window gives access to the clock select, the count, both compare values, the enables and the flags. The same window also reads them back. One PWM pin goes high at each wrap and low when the count reaches the channel-A compare value. Software writes to channel A land in a holding register. The holding value is copied into the comparator only at a wrap, so a duty-cycle change never cuts a period short.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count, both compare values, the enables, the flags, the interrupt lines and the PWM pin are all 0, and the clock select is 0 (stopped).
- R2: The clock select at address 0, bits [2:0], picks the count rate: 0 stops the counter; 1, 2, 3, 4 and 5 advance it once every 1, 8, 64, 256 and 1024 clocks; 6 and 7 also stop it. Starting from select 0, a write of select code s makes the count after k further clocks equal k divided by the divider (integer division).
- R3: The count at address 1 and the channel-B compare value at address 3 can be written and read back. A count write takes priority over an advance in the same cycle.
- R4: The flag for a compare channel (flags at address 5: bit 1 for channel A, bit 2 for channel B) sets at the advance that moves the count away from the matching value. While the count equals the compare value, the flag is still 0.
- R5: The wrap flag (flag bit 0) sets at the advance that takes the count from 255 to 0.
- R6: Each interrupt line is 1 exactly when its flag and its enable bit (address 4, same bit order as the flags) are both 1.
- R7: A 1 on an acknowledge input for one cycle clears that source's flag.
- R8: Writing flags with a 1 in a bit clears that flag. Writing 0 in a bit leaves that flag unchanged.
- R9: If a flag is set by an event and cleared by a write in the same cycle, the flag ends up set.
- R10: The PWM pin rises at the advance into count 0. It falls at the advance into the active channel-A compare value.
- R11: A write to channel A (address 2) is stored in a holding register and reads back at once. The comparator uses the new value only from the next wrap on.
- R12: Running at full rate in steady state with channel-A value v, the PWM pin is high for exactly v of every 256 clocks. So v=0 keeps it low and v=255 leaves it low for one count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_ack | input | 3 | Acknowledge per source (bit 0 wrap, 1 channel A, 2 channel B) |
| irq | output | 3 | Interrupt request per source |
| pwm_out | output | 1 | PWM output |

## Verification
Register writes take effect at the clock edge of the write. Read data follows the address in the same cycle. The first advance after a start from select 0 comes exactly one divider length after the write edge, so the bench counts clocks from that edge and compares the read count with its own division. Flags appear one advance after the count reaches a match, and the PWM pin moves at the edge the count changes. The bench reads each one just before that edge and again just after it. For duty measurements it waits more than one full period after a compare write, then sums the pin over exactly 256 falling-edge samples.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

   localparam int unsigned SRC_N   = 3;
   localparam int unsigned SRC_OVF = 0;
   localparam int unsigned SRC_A   = 1;
   localparam int unsigned SRC_B   = 2;

   typedef enum logic [2:0] {
      REG_CTRL = 3'd0,
      REG_CNT  = 3'd1,
      REG_CMPA = 3'd2,
      REG_CMPB = 3'd3,
      REG_IEN  = 3'd4,
      REG_FLAG = 3'd5
   } reg_addr_e;

   // log2 of the divide ratio for each select code
   function automatic int unsigned sel_shift(input logic [2:0] s);
      case (s)
         3'd2:    return 3;
         3'd3:    return 6;
         3'd4:    return 8;
         3'd5:    return 10;
         default: return 0;
      endcase
   endfunction

   function automatic logic sel_run(input logic [2:0] s);
      return (s != 3'd0) && (s <= 3'd5);
   endfunction

endpackage

// File: rtl/cmp_timer_psc.sv
module cmp_timer_psc #(
   parameter int unsigned DIV_W = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   output logic       tick
);
   import cmp_timer_pkg::*;

   if (DIV_W < 10) begin : g_bad_div
      $error("DIV_W must cover the largest divide ratio");
   end

   logic [DIV_W-1:0] psc;
   logic [DIV_W-1:0] mask;
   logic             run;

   always_comb begin
      run  = sel_run(sel);
      mask = (DIV_W'(1) << sel_shift(sel)) - DIV_W'(1);
      tick = run && ((psc & mask) == mask);
   end

   // phase restarts from zero whenever the timer is stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   psc <= '0;
      else if (!run) psc <= '0;
      else          psc <= psc + DIV_W'(1);
   end

   a_r2_stopped_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (psc == '0));

endmodule

// File: rtl/cmp_timer_flags.sv
module cmp_timer_flags #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hit,
   input  logic [N-1:0] ack,
   input  logic         clr_en,
   input  logic [N-1:0] clr_mask,
   input  logic [N-1:0] ien,
   output logic [N-1:0] flag,
   output logic [N-1:0] irq
);

   if (N < 1) begin : g_bad_n
      $error("N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_src
      logic flag_q;
      logic clr_i;

      assign clr_i = ack[i] | (clr_en & clr_mask[i]);

      // an event beats a clear so nothing is lost
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag_q <= 1'b0;
         else if (hit[i]) flag_q <= 1'b1;
         else if (clr_i)  flag_q <= 1'b0;
      end

      assign flag[i] = flag_q;
      assign irq[i]  = flag_q & ien[i];

      a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         hit[i] |=> flag[i]);
      a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && !hit[i]) |=> !flag[i]);
      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i && !hit[i]) |=> $stable(flag[i]));
   end

endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic [CNT_W-1:0] cmpa_buf,
   input  logic [CNT_W-1:0] cmpb,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cmpa_act,
   output logic             pwm,
   output logic             hit_ovf,
   output logic             hit_a,
   output logic             hit_b
);
   localparam logic [CNT_W-1:0] TOP = '1;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             adv;
   logic             at_top;
   logic [CNT_W-1:0] cnt_nx;
   logic [CNT_W-1:0] cmp_nx;

   always_comb begin
      adv     = tick && !cnt_we;
      at_top  = (cnt == TOP);
      cnt_nx  = cnt + ONE;
      cmp_nx  = at_top ? cmpa_buf : cmpa_act;
      hit_ovf = adv && at_top;
      hit_a   = adv && (cnt == cmpa_act);
      hit_b   = adv && (cnt == cmpb);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         cmpa_act <= '0;
         pwm      <= 1'b0;
      end else begin
         if (cnt_we)   cnt <= cnt_wdata;
         else if (adv) cnt <= cnt_nx;
         if (adv && at_top) cmpa_act <= cmpa_buf;
         if (adv) begin
            // reaching the compare value wins over the wrap rise
            if (cnt_nx == cmp_nx) pwm <= 1'b0;
            else if (at_top)      pwm <= 1'b1;
         end
      end
   end

   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && at_top) |=> (cnt == '0));
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_we) |=> $stable(cnt));
   a_r10_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm) |-> (cnt == '0));
   a_r10_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwm) |-> (cnt == cmpa_act));
   a_r11_reload: assert property (@(posedge clk) disable iff (!rst_n)
      !(adv && at_top) |=> $stable(cmpa_act));
   a_r12_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpa_act == '0) |-> !pwm);

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       bus_addr,
   input  logic             bus_we,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic [2:0]       irq_ack,
   output logic [2:0]       irq,
   output logic             pwm_out
);
   import cmp_timer_pkg::*;

   if (CNT_W < 4) begin : g_bad_w
      $error("CNT_W must hold the select and flag fields");
   end

   logic [2:0]       sel_q;
   logic [CNT_W-1:0] cmpa_buf;
   logic [CNT_W-1:0] cmpb;
   logic [SRC_N-1:0] ien;
   logic [SRC_N-1:0] flag;
   logic [SRC_N-1:0] hit;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cmpa_act;
   logic             tick;
   logic             hit_ovf;
   logic             hit_a;
   logic             hit_b;
   logic             cnt_we;
   logic             flag_we;

   assign cnt_we  = bus_we && (bus_addr == REG_CNT);
   assign flag_we = bus_we && (bus_addr == REG_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= '0;
         cmpa_buf <= '0;
         cmpb     <= '0;
         ien      <= '0;
      end else if (bus_we) begin
         case (bus_addr)
            REG_CTRL: sel_q    <= bus_wdata[2:0];
            REG_CMPA: cmpa_buf <= bus_wdata;
            REG_CMPB: cmpb     <= bus_wdata;
            REG_IEN:  ien      <= bus_wdata[SRC_N-1:0];
            default:  ;
         endcase
      end
   end

   cmp_timer_psc #(.DIV_W(DIV_W)) u_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (sel_q),
      .tick (tick)
   );

   cmp_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .cnt_we   (cnt_we),
      .cnt_wdata(bus_wdata),
      .cmpa_buf (cmpa_buf),
      .cmpb     (cmpb),
      .cnt      (cnt),
      .cmpa_act (cmpa_act),
      .pwm      (pwm_out),
      .hit_ovf  (hit_ovf),
      .hit_a    (hit_a),
      .hit_b    (hit_b)
   );

   always_comb begin
      hit          = '0;
      hit[SRC_OVF] = hit_ovf;
      hit[SRC_A]   = hit_a;
      hit[SRC_B]   = hit_b;
   end

   cmp_timer_flags #(.N(SRC_N)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .ack     (irq_ack),
      .clr_en  (flag_we),
      .clr_mask(bus_wdata[SRC_N-1:0]),
      .ien     (ien),
      .flag    (flag),
      .irq     (irq)
   );

   always_comb begin
      case (bus_addr)
         REG_CTRL: bus_rdata = CNT_W'(sel_q);
         REG_CNT:  bus_rdata = cnt;
         REG_CMPA: bus_rdata = cmpa_buf;
         REG_CMPB: bus_rdata = cmpb;
         REG_IEN:  bus_rdata = CNT_W'(ien);
         REG_FLAG: bus_rdata = CNT_W'(flag);
         default:  bus_rdata = '0;
      endcase
   end

   a_r3_cnt_write: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> (cnt == $past(bus_wdata)));
   a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == '0) |-> (irq == '0));

endmodule

// File: tb/cmp_timer_bench.sv
`timescale 1ns/1ps
module cmp_timer_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       we = 1'b0;
   logic [7:0] wd = '0;
   logic [7:0] rd;
   logic [2:0] ack = '0;
   logic [2:0] irq;
   logic       pwm;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   cmp_timer u_cmp_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wd), .bus_rdata(rd), .irq_ack(ack), .irq(irq), .pwm_out(pwm)
   );

   always #10 clk = ~clk;

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 150000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
         report();
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // call at a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      addr = a; wd = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rdr(input logic [2:0] a, output int v);
      addr = a;
      #1;
      v = int'(rd);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int exp_count(input int k, input int div);
      return k / div;
   endfunction

   function automatic int exp_high(input int v);
      return v;
   endfunction

   function automatic int div_of(input int s);
      case (s)
         1: return 1;
         2: return 8;
         3: return 64;
         4: return 256;
         5: return 1024;
         default: return 0;
      endcase
   endfunction

   initial begin
      int v;
      int c;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rdr(3'd1, v); chk("R1 count", v, 0);
      rdr(3'd5, v); chk("R1 flags", v, 0);
      rdr(3'd0, v); chk("R1 select", v, 0);
      rdr(3'd2, v); chk("R1 compare A", v, 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 pwm", int'(pwm), 0);

      // R3 register access, R11 buffered read back
      wr(3'd1, 8'hA5); rdr(3'd1, v); chk("R3 count readback", v, 165);
      wr(3'd3, 8'd60); rdr(3'd3, v); chk("R3 compare B readback", v, 60);
      wr(3'd2, 8'd77); rdr(3'd2, v); chk("R11 compare A readback", v, 77);
      wr(3'd2, 8'd0);

      // R2 every divider, checked both sides of the second advance
      for (int s = 1; s <= 5; s++) begin
         int d;
         d = div_of(s);
         wr(3'd0, 8'd0); wr(3'd1, 8'd0); wr(3'd0, 8'(s));
         idle(2 * d - 1);
         rdr(3'd1, v); chk("R2 count before edge", v, exp_count(2 * d - 1, d));
         idle(1);
         rdr(3'd1, v); chk("R2 count at edge", v, exp_count(2 * d, d));
      end
      wr(3'd0, 8'd0); rdr(3'd1, c); idle(20); rdr(3'd1, v); chk("R2 stopped", v, c);
      wr(3'd0, 8'd6); idle(20); rdr(3'd1, v); chk("R2 code 6 stopped", v, c);
      for (int r = 0; r < 4; r++) begin
         int s;
         int k;
         s = 1 + int'($urandom % 3);
         k = 1 + int'($urandom % 250);
         wr(3'd0, 8'd0); wr(3'd1, 8'd0); wr(3'd0, 8'(s));
         idle(k);
         rdr(3'd1, v); chk("R2 random run", v, exp_count(k, div_of(s)));
      end

      // R4 channel B flag one advance after equality
      wr(3'd0, 8'd0); wr(3'd5, 8'd7); wr(3'd3, 8'd10); wr(3'd1, 8'd10);
      wr(3'd0, 8'd1);
      rdr(3'd5, v); chk("R4 B flag not yet", (v >> 2) & 1, 0);
      idle(1);
      rdr(3'd5, v); chk("R4 B flag set", (v >> 2) & 1, 1);

      // R5 wrap flag, R4 channel A flag after the count leaves 0
      wr(3'd0, 8'd0); wr(3'd5, 8'd7); wr(3'd1, 8'd254); wr(3'd0, 8'd1);
      idle(1);
      rdr(3'd5, v); chk("R5 wrap flag before", v & 1, 0);
      rdr(3'd1, v); chk("R5 count at top", v, 255);
      idle(1);
      rdr(3'd5, v); chk("R5 wrap flag set", v & 1, 1);
      chk("R4 A flag not yet", (v >> 1) & 1, 0);
      rdr(3'd1, v); chk("R5 count wrapped", v, 0);
      idle(1);
      rdr(3'd5, v); chk("R4 A flag set", (v >> 1) & 1, 1);
      wr(3'd0, 8'd0);

      // R6 enable gating (flags now 3)
      wr(3'd4, 8'd0); chk("R6 none enabled", int'(irq), 0);
      wr(3'd4, 8'd1); chk("R6 wrap enabled", int'(irq), 1);
      wr(3'd4, 8'd2); chk("R6 A enabled", int'(irq), 2);
      wr(3'd4, 8'd0);

      // R8 write zero keeps, write one clears
      wr(3'd5, 8'd0); rdr(3'd5, v); chk("R8 zero write no effect", v, 3);
      wr(3'd5, 8'd2); rdr(3'd5, v); chk("R8 one clears A only", v, 1);

      // R7 acknowledge
      ack = 3'b001; @(negedge clk); ack = 3'b000;
      rdr(3'd5, v); chk("R7 ack clears wrap flag", v, 0);

      // R9 set and clear in the same cycle
      wr(3'd5, 8'd7); wr(3'd0, 8'd1); wr(3'd1, 8'd255); wr(3'd5, 8'd1);
      rdr(3'd5, v); chk("R9 set beats clear", v & 1, 1);

      // R10 / R11 edges of the PWM pin
      wr(3'd0, 8'd0); wr(3'd2, 8'd100); wr(3'd1, 8'd250); wr(3'd0, 8'd1);
      idle(5); chk("R10 low before wrap", int'(pwm), 0);
      idle(1); chk("R10 high after wrap", int'(pwm), 1);
      wr(3'd2, 8'd200);
      idle(98); chk("R11 old value still high", int'(pwm), 1);
      idle(1);  chk("R11 old value falls", int'(pwm), 0);
      idle(355); chk("R11 new value still high", int'(pwm), 1);
      idle(1);  chk("R11 new value falls", int'(pwm), 0);

      // R12 duty over one full period
      for (int r = 0; r < 8; r++) begin
         int dv;
         int high;
         if (r == 0)      dv = 0;
         else if (r == 1) dv = 255;
         else             dv = int'($urandom % 256);
         wr(3'd2, 8'(dv));
         idle(300);
         high = 0;
         repeat (256) begin
            @(negedge clk);
            high += int'(pwm);
         end
         chk("R12 duty", high, exp_high(dv));
      end

      report();
   end

endmodule